// File: doc/BRIEF.md
# Hall Commutation Decoder with Brake

This block converts the three position-sensor inputs of a three-phase brushless motor, together with an already settled direction bit, into six power-stage commands. Each phase has a high-side command, which is active low (0 turns the device on), and a low-side command, which is active high. In each of the six valid sensor states, exactly one phase sources current and another phase sinks it.

A PWM chop signal removes drive in one of two ways. In two-quadrant mode only the low side is switched. In four-quadrant mode both the high side and the low side are switched. A brake request overrides the sensors and the chop-mode select: it turns every high side off and every low side on. Three inhibit flags cut all drive, both in normal running and during braking. These flags stand for low supply, peak current and coast/overvoltage. A per-input inversion mask lets a 60-degree sensor set be decoded with the same table.

The sensor inputs are synchronized on entry. Each change between two valid sensor codes raises a one-cycle tachometer request, but not while braking.

Top module: `bldc_commutator`

## Requirements
- R1: After a cycle with rst_n low, pu_n is 3'b111, pd is 3'b000 and tach_req is 0.
- R2: With dir=0 and no chop, brake or inhibit, the corrected code {h2,h1,h0} selects a source phase and a sink phase as follows: 001 gives A and B, 011 gives A and C, 010 gives B and C, 110 gives B and A, 100 gives C and A, 101 gives C and B. The source phase has its pu_n bit at 0 and the sink phase has its pd bit at 1; bit 0 is phase A, bit 1 is B and bit 2 is C. All other bits are off.
- R3: With dir=1, the source phase and the sink phase of R2 are exchanged.
- R4: With chop_on=1 and quad_sel=0 (two-quadrant), pd is 3'b000 and pu_n keeps its unchopped value.
- R5: With chop_on=1 and quad_sel=1 (four-quadrant), pu_n is 3'b111 and pd is 3'b000.
- R6: With brake=1, pu_n is 3'b111 and pd is 3'b111 when chop_on=0, or 3'b000 when chop_on=1. The sensor code and quad_sel have no effect.
- R7: When any of inh_uv, inh_peak or inh_coast is 1, pu_n is 3'b111 and pd is 3'b000. This also holds during brake.
- R8: When brake is 0, the corrected codes 000 and 111 give pu_n=3'b111 and pd=3'b000.
- R9: The corrected code is the synchronized sensor code XOR inv_mask, bit for bit.
- R10: tach_req is 1 for exactly one cycle when the corrected code changes from one valid value to another valid value. It stays 0 while brake is 1.
- R11: A sensor change reaches pu_n, pd and tach_req on the third rising edge after it is applied (two synchronizer stages plus the output register). A change on any other input reaches the outputs on the next rising edge.
- R12: No phase ever has pu_n[i]=0 and pd[i]=1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall | input | 3 | Raw sensor inputs {h2,h1,h0} |
| inv_mask | input | 3 | Per-input inversion applied after synchronization |
| dir | input | 1 | Settled direction, 1 = reverse |
| quad_sel | input | 1 | Chop mode: 0 two-quadrant, 1 four-quadrant |
| chop_on | input | 1 | PWM chop request, 1 removes drive |
| brake | input | 1 | Brake request |
| inh_uv | input | 1 | Low-supply inhibit |
| inh_peak | input | 1 | Peak-current inhibit |
| inh_coast | input | 1 | Coast/overvoltage inhibit |
| pu_n | output | 3 | High-side commands, active low |
| pd | output | 3 | Low-side commands, active high |
| tach_req | output | 1 | One-cycle tachometer request |

## Verification
The assertions check on every cycle that no phase has its high and low devices on together. They also check that the cycle after a brake, inhibit, chop or invalid-code condition shows the matching all-off or low-side-only pattern, and that no tachometer request appears after a braking cycle.

Only the bench scenarios can show the following:
- the six-step table contents, including the direction swap and the 60-degree decode through the inversion mask;
- the exact three-edge latency of sensor changes;
- the single-cycle tachometer pulse that follows each valid sensor step.

// File: rtl/comm_pkg.sv
// Shared types and helpers for the commutation decoder.
// Assumes a three-phase machine; bit 0 = phase A, 1 = B, 2 = C.
package comm_pkg;
    localparam int NPH = 3;

    typedef struct packed {
        logic [NPH-1:0] src;   // one-hot phase that sources current
        logic [NPH-1:0] snk;   // one-hot phase that sinks current
        logic           ok;    // code is one of the six valid states
    } step_t;

    // A code is valid when not all inputs agree.
    function automatic logic code_valid(input logic [NPH-1:0] c);
        return (c != '0) && (c != '1);
    endfunction
endpackage

// File: rtl/hall_conditioner.sv
// Synchronizes the raw sensor inputs, applies the inversion mask and
// raises a one-cycle tachometer request on each valid-to-valid change.
// Assumes inputs are asynchronous to clk; SYNC_STAGES >= 1.
module hall_conditioner
    import comm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] hall_raw,
    input  logic [NPH-1:0] inv_mask,
    input  logic           brake,
    output logic [NPH-1:0] code,
    output logic           tach_req
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [NPH-1:0] sync_q [SYNC_STAGES];
    logic [NPH-1:0] prev_q;
    logic           tach_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First capture stage of the synchronizer.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= '0;
                else        sync_q[0] <= hall_raw;
            end
        end else begin : g_next
            // Further synchronizer stages.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= '0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Corrected code after per-input inversion.
    assign code = sync_q[LAST] ^ inv_mask;

    // Edge detector producing the tachometer request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            tach_q <= 1'b0;
        end else begin
            prev_q <= code;
            tach_q <= (code != prev_q) && code_valid(code)
                      && code_valid(prev_q) && !brake;
        end
    end

    assign tach_req = tach_q;

    p_tach_brake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brake |=> !tach_req);

    p_tach_needs_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (code == prev_q) |=> !tach_req);
endmodule

// File: rtl/step_decoder.sv
// Maps a corrected sensor code and direction to the source/sink phases
// of the six-step sequence. Purely combinational; reverse swaps roles.
module step_decoder
    import comm_pkg::*;
(
    input  logic [NPH-1:0] code,
    input  logic           dir,
    output step_t          step
);
    logic [NPH-1:0] fwd_src;
    logic [NPH-1:0] fwd_snk;

    // Forward six-step table.
    always_comb begin
        unique case (code)
            3'b001:  begin fwd_src = 3'b001; fwd_snk = 3'b010; end
            3'b011:  begin fwd_src = 3'b001; fwd_snk = 3'b100; end
            3'b010:  begin fwd_src = 3'b010; fwd_snk = 3'b100; end
            3'b110:  begin fwd_src = 3'b010; fwd_snk = 3'b001; end
            3'b100:  begin fwd_src = 3'b100; fwd_snk = 3'b001; end
            3'b101:  begin fwd_src = 3'b100; fwd_snk = 3'b010; end
            default: begin fwd_src = 3'b000; fwd_snk = 3'b000; end
        endcase
    end

    // Direction swap and validity flag.
    always_comb begin
        step.src = dir ? fwd_snk : fwd_src;
        step.snk = dir ? fwd_src : fwd_snk;
        step.ok  = code_valid(code);
    end
endmodule

// File: rtl/drive_stage.sv
// Applies chop mode, brake override and inhibits to the decoded step and
// registers the six power commands. High side active low, low side active high.
module drive_stage
    import comm_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  step_t          step,
    input  logic           brake,
    input  logic           chop_on,
    input  logic           quad_sel,
    input  logic           inhibit,
    output logic [NPH-1:0] pu_n,
    output logic [NPH-1:0] pd
);
    logic [NPH-1:0] hs_on;
    logic [NPH-1:0] ls_on;
    logic [NPH-1:0] pu_n_q;
    logic [NPH-1:0] pd_q;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        // Per-phase drive decision.
        always_comb begin
            if (inhibit) begin
                hs_on[p] = 1'b0;
                ls_on[p] = 1'b0;
            end else if (brake) begin
                hs_on[p] = 1'b0;
                ls_on[p] = !chop_on;
            end else if (!step.ok) begin
                hs_on[p] = 1'b0;
                ls_on[p] = 1'b0;
            end else begin
                hs_on[p] = step.src[p] && !(chop_on && quad_sel);
                ls_on[p] = step.snk[p] && !chop_on;
            end
        end

        // Per-phase output register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pu_n_q[p] <= 1'b1;
                pd_q[p]   <= 1'b0;
            end else begin
                pu_n_q[p] <= !hs_on[p];
                pd_q[p]   <= ls_on[p];
            end
        end
    end

    assign pu_n = pu_n_q;
    assign pd   = pd_q;

    p_no_shoot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pd & ~pu_n) == '0);

    p_brake_hs_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brake |=> (pu_n == '1));

    p_inhibit_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> (pu_n == '1 && pd == '0));

    p_two_quad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit && !brake && chop_on && !quad_sel) |=> (pd == '0));

    p_four_quad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit && !brake && chop_on && quad_sel) |=> (pu_n == '1 && pd == '0));

    p_invalid_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!brake && !step.ok) |=> (pu_n == '1 && pd == '0));

    p_single_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~pu_n) <= 1);
endmodule

// File: rtl/bldc_commutator.sv
// Top of the commutation decoder: sensor conditioning, six-step decode and
// the registered power-stage drive. Direction is assumed already settled.
module bldc_commutator
    import comm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall,
    input  logic [2:0] inv_mask,
    input  logic       dir,
    input  logic       quad_sel,
    input  logic       chop_on,
    input  logic       brake,
    input  logic       inh_uv,
    input  logic       inh_peak,
    input  logic       inh_coast,
    output logic [2:0] pu_n,
    output logic [2:0] pd,
    output logic       tach_req
);
    logic [NPH-1:0] code;
    step_t          step;
    logic           inhibit;

    assign inhibit = inh_uv | inh_peak | inh_coast;

    hall_conditioner #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hall_raw (hall),
        .inv_mask (inv_mask),
        .brake    (brake),
        .code     (code),
        .tach_req (tach_req)
    );

    step_decoder dec_i (
        .code (code),
        .dir  (dir),
        .step (step)
    );

    drive_stage drv_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .brake    (brake),
        .chop_on  (chop_on),
        .quad_sel (quad_sel),
        .inhibit  (inhibit),
        .pu_n     (pu_n),
        .pd       (pd)
    );

    p_valid_has_sink_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step.ok && !inhibit && !brake && !chop_on) |=> ($countones(pd) == 1));
endmodule

// File: tb/bldc_commutator_tb_top.sv
module bldc_commutator_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] hall, inv_mask;
    logic       dir, quad_sel, chop_on, brake, inh_uv, inh_peak, inh_coast;
    logic [2:0] pu_n, pd;
    logic       tach_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bldc_commutator dut_i (.*);

    // Bench reference model state.
    logic [2:0] m_s1, m_s2, m_prev, e_pu, e_pd;
    logic       e_tach;
    string      e_tag;

    function automatic logic ok3(input logic [2:0] c);
        return (c != 3'b000) && (c != 3'b111);
    endfunction

    // Six-step table from R2: returns {src, snk}.
    function automatic logic [5:0] table_fwd(input logic [2:0] c);
        case (c)
            3'b001: return {3'b001, 3'b010};
            3'b011: return {3'b001, 3'b100};
            3'b010: return {3'b010, 3'b100};
            3'b110: return {3'b010, 3'b001};
            3'b100: return {3'b100, 3'b001};
            3'b101: return {3'b100, 3'b010};
            default: return 6'b0;
        endcase
    endfunction

    function automatic logic [5:0] ref_out(input logic [2:0] c, input logic d,
            input logic q, input logic ch, input logic br, input logic inh);
        logic [5:0] t;
        logic [2:0] s, k;
        t = table_fwd(c);
        s = d ? t[2:0] : t[5:3];
        k = d ? t[5:3] : t[2:0];
        if (inh) return {3'b111, 3'b000};
        if (br) return {3'b111, ch ? 3'b000 : 3'b111};
        if (!ok3(c)) return {3'b111, 3'b000};
        return {~(s & {3{!(ch && q)}}), k & {3{!ch}}};
    endfunction

    function automatic string ref_tag(input logic [2:0] c, input logic [2:0] m,
            input logic d, input logic q, input logic ch, input logic br, input logic inh);
        if (inh) return "R7";
        if (br) return "R6";
        if (!ok3(c)) return "R8";
        if (ch) return q ? "R5" : "R4";
        if (m != 3'b000) return "R9";
        return d ? "R3" : "R2";
    endfunction

    // Cycle model built from the requirements (R11 latency).
    always @(posedge clk) begin
        logic [2:0] cur;
        logic [5:0] o;
        logic       inh;
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0;
            e_pu <= 3'b111; e_pd <= 3'b000; e_tach <= 0; e_tag <= "R1";
        end else begin
            cur = m_s2 ^ inv_mask;
            inh = inh_uv | inh_peak | inh_coast;
            o = ref_out(cur, dir, quad_sel, chop_on, brake, inh);
            e_pu <= o[5:3];
            e_pd <= o[2:0];
            e_tag <= ref_tag(cur, inv_mask, dir, quad_sel, chop_on, brake, inh);
            e_tach <= (cur != m_prev) && ok3(cur) && ok3(m_prev) && !brake;
            m_s1 <= hall; m_s2 <= m_s1; m_prev <= cur;
        end
    end

    task automatic chk(input bit good, input string req, input string what,
            input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(pu_n === e_pu, e_tag, "pu_n", pu_n, e_pu);
        chk(pd === e_pd, e_tag, "pd", pd, e_pd);
        chk(tach_req === e_tach, "R10", "tach_req", {2'b0, tach_req}, {2'b0, e_tach});
        chk((pd & ~pu_n) == 3'b000, "R12", "shoot-through", pd & ~pu_n, 3'b000);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        inv_mask = 0; dir = 0; quad_sel = 0; chop_on = 0; brake = 0;
        inh_uv = 0; inh_peak = 0; inh_coast = 0;
    endtask

    localparam logic [2:0] SEQ [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
    localparam logic [2:0] SEQ60 [6] = '{3'b000, 3'b001, 3'b011, 3'b111, 3'b110, 3'b100};

    initial begin
        int idx;
        int r;
        void'($urandom(32'd1234));
        rst_n = 0; hall = 3'b001; idle_inputs();
        @(negedge clk);
        repeat (3) tick();
        chk(pu_n === 3'b111 && pd === 3'b000 && tach_req === 1'b0, "R1",
            "reset outputs", pu_n ^ pd, 3'b111);
        @(negedge clk) rst_n = 1;
        repeat (4) tick();

        // R11 latency and R10 single pulse: 001 -> 011, dir 0.
        chk(pd === 3'b010 && pu_n === 3'b110, "R2", "steady 001", pd, 3'b010);
        hall = 3'b011;
        tick(); chk(pd === 3'b010, "R11", "pd after edge 1", pd, 3'b010);
        tick(); chk(pd === 3'b010, "R11", "pd after edge 2", pd, 3'b010);
        tick(); chk(pd === 3'b100, "R11", "pd after edge 3", pd, 3'b100);
        chk(tach_req === 1'b1, "R10", "tach on step", {2'b0, tach_req}, 3'b001);
        tick(); chk(tach_req === 1'b0, "R10", "tach one cycle", {2'b0, tach_req}, 3'b000);

        // R3 reverse direction, reaches outputs after one edge.
        dir = 1; tick();
        chk(pu_n === 3'b011 && pd === 3'b001, "R3", "reverse 011 pu_n", pu_n, 3'b011);

        // R6 brake ignores quad_sel and code; R10 no tach during brake.
        brake = 1; quad_sel = 1; hall = 3'b010;
        repeat (4) tick();
        chk(pu_n === 3'b111 && pd === 3'b111, "R6", "brake pd", pd, 3'b111);
        chop_on = 1; tick();
        chk(pd === 3'b000, "R6", "brake chopped pd", pd, 3'b000);
        chop_on = 0; inh_peak = 1; tick();
        chk(pd === 3'b000, "R7", "brake inhibited pd", pd, 3'b000);
        inh_peak = 0; brake = 0; quad_sel = 0; dir = 0;

        // R8 invalid codes.
        hall = 3'b111; repeat (3) tick();
        chk(pu_n === 3'b111 && pd === 3'b000, "R8", "code 111", pd, 3'b000);
        hall = 3'b000; repeat (3) tick();
        chk(pu_n === 3'b111 && pd === 3'b000, "R8", "code 000", pd, 3'b000);

        // R9: 60-degree sequence decoded with middle input inverted.
        inv_mask = 3'b010;
        for (int k = 0; k < 12; k++) begin
            hall = SEQ60[k % 6];
            repeat (3) tick();
            chk(pd !== 3'b000, "R9", "60-degree step drives", pd, 3'b111);
        end
        inv_mask = 0;

        // Constrained random run.
        idx = 0;
        for (int n = 0; n < 4000; n++) begin
            r = $urandom_range(0, 99);
            if (r < 25) idx = (idx + 1) % 6;
            else if (r < 35) idx = (idx + 5) % 6;
            hall = (r == 99) ? 3'b000 : (r == 98) ? 3'b111 : SEQ[idx];
            brake = ($urandom_range(0, 9) == 0);
            chop_on = ($urandom_range(0, 2) == 0);
            quad_sel = $urandom_range(0, 1) == 1;
            inh_uv = ($urandom_range(0, 29) == 0);
            inh_peak = ($urandom_range(0, 29) == 0);
            inh_coast = ($urandom_range(0, 29) == 0);
            if ($urandom_range(0, 49) == 0) dir = ~dir;
            if ($urandom_range(0, 199) == 0) inv_mask = 3'($urandom_range(0, 7));
            tick();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule